// File: doc/BRIEF.md
# Dword Parity Checker with Error Reporting

This block sits at the egress side of a link layer and checks a stream of 32-bit data words, one word per beat. Each word arrives with its own even-parity bit. A packet is framed by a start marker and an end marker. If any word of a packet fails parity while checking is on, the block marks that packet for nullification when it ends. The framing logic further down then inverts the link CRC and closes the packet with the bad-end symbol. Neither of those two steps is done here.

Each erroneous packet also updates the error record:
- A sticky status bit is set. Software clears it by writing 1.
- A saturating counter goes up by one. Reading the counter clears it.
- If reporting is enabled, a one-cycle message request is raised, tagged as a non-fatal error. It is raised only when the status bit goes from 0 to 1.

A disable input turns checking off completely. After reset, checking is on and no error is recorded.

Top module: `dw_parity_check`

## Requirements
- R1: A word is in error when the XOR of its DATA_W data bits and its parity bit is 1, that is, when even parity is broken. A word whose parity bit equals the XOR of its data bits is good.
- R2: One cycle after a valid beat with `in_eop`=1, `out_eop` is 1. `out_null` is 1 in that same cycle only if some checked word of the packet was in error. For a packet with no error, `out_null` stays 0.
- R3: The first packet error sets `err_sts` to 1. The bit stays 1 until `sts_clr` is pulsed, and it reads 0 in the cycle after the pulse. If a packet error and `sts_clr` arrive in the same cycle, `err_sts` stays 1.
- R4: Each erroneous packet adds 1 to `err_cnt` in the cycle after its end beat. The counter holds at 2^CNT_W-1 and does not wrap. Outside a read, the counter never decreases.
- R5: A `cnt_rd` pulse returns the current `err_cnt` and clears it to 0 in the next cycle. If `cnt_rd` and a packet error arrive in the same cycle, the counter becomes 1.
- R6: `msg_req` is a one-cycle pulse with `msg_kind`=2'b01 (non-fatal). It is raised together with the packet's `out_null` only when `rpt_en` is 1 and `err_sts` was 0 before that error. Later errors raise no message until `err_sts` has been cleared and is set again. When `msg_req` is 0, `msg_kind` is 2'b00.
- R7: While `chk_disable` is 1, words are not checked. A packet whose bad words all arrive with `chk_disable`=1 ends with `out_null`=0 and leaves `err_sts`, `err_cnt` and `msg_req` unchanged.
- R8: After reset, `out_eop`, `out_null`, `err_sts`, `err_cnt`, `msg_req` and `msg_kind` are all 0.
- R9: A packet with several bad words counts as one error: `err_cnt` goes up by exactly 1.
- R10: Beats with `in_valid`=0 have no effect, whatever their data, parity or framing bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is present on this beat |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| in_data | input | DATA_W | Data word |
| in_par | input | 1 | Even-parity bit for `in_data` |
| chk_disable | input | 1 | 1 turns parity checking off |
| rpt_en | input | 1 | 1 allows message requests |
| cnt_rd | input | 1 | Read strobe for the counter; clears it |
| sts_clr | input | 1 | Write-1 strobe that clears the status bit |
| out_eop | output | 1 | Registered packet-end marker |
| out_null | output | 1 | Packet that just ended must be nullified |
| err_sts | output | 1 | Sticky error status |
| err_cnt | output | CNT_W | Saturating error count |
| msg_req | output | 1 | One-cycle error message request |
| msg_kind | output | 2 | Message class, 2'b01 = non-fatal |

## Verification
The bench builds the block with DATA_W=32 and LANE_W=8, so every lane of the parity tree is exercised. It sets CNT_W=4, which brings counter saturation at 15 within a couple of dozen packets. At the 8-bit default, saturation would need hundreds of packets. The same short counter width lets the bench land a read-clear and a new error in the same cycle, and a status clear and a new error in the same cycle, at chosen points in the count.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    MSG_NONE     = 2'b00,
    MSG_NONFATAL = 2'b01,
    MSG_FATAL    = 2'b10
  } msg_kind_e;

  // severity used for end-to-end parity errors after reset
  localparam msg_kind_e PARITY_MSG_KIND = MSG_NONFATAL;

endpackage

// File: rtl/dpc_lane_parity.sv
module dpc_lane_parity #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              word_bad
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_x;

  // lane-wise XOR first keeps each tree shallow, then one small combine
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_x[g] = ^data[g*LANE_W +: LANE_W];
  end

  assign word_bad = ^{lane_x, par};
endmodule

// File: rtl/dpc_pkt_track.sv
module dpc_pkt_track (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic sop,
  input  logic eop,
  input  logic word_bad,
  input  logic chk_disable,
  output logic pkt_evt,
  output logic out_eop,
  output logic out_null
);
  logic pkt_err_q;
  logic prior_err;
  logic hit;

  // a start beat discards any leftover flag from an unterminated packet
  assign prior_err = (sop) ? 1'b0 : pkt_err_q;
  assign hit       = valid & ~chk_disable & word_bad;
  assign pkt_evt   = valid & eop & (prior_err | hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_err_q <= 1'b0;
      out_eop   <= 1'b0;
      out_null  <= 1'b0;
    end else begin
      if (valid) begin
        pkt_err_q <= eop ? 1'b0 : (prior_err | hit);
      end
      out_eop  <= valid & eop;
      out_null <= pkt_evt;
    end
  end
endmodule

// File: rtl/dpc_sat_cnt.sv
module dpc_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] bumped;

  assign bumped = (value == TOP) ? TOP : value + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else begin
      unique case ({clr, inc})
        2'b11:   value <= {{(CNT_W-1){1'b0}}, 1'b1};
        2'b10:   value <= '0;
        2'b01:   value <= bumped;
        default: value <= value;
      endcase
    end
  end
endmodule

// File: rtl/dpc_err_report.sv
module dpc_err_report
  import dpc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_evt,
  input  logic             rpt_en,
  input  logic             sts_clr,
  input  logic             cnt_rd,
  output logic             err_sts,
  output logic [CNT_W-1:0] err_cnt,
  output logic             msg_req,
  output logic [1:0]       msg_kind
);
  logic rise;

  // message only on a 0->1 change of the status bit
  assign rise = pkt_evt & ~err_sts;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_sts  <= 1'b0;
      msg_req  <= 1'b0;
      msg_kind <= MSG_NONE;
    end else begin
      if (pkt_evt)      err_sts <= 1'b1;
      else if (sts_clr) err_sts <= 1'b0;
      msg_req  <= rise & rpt_en;
      msg_kind <= (rise & rpt_en) ? PARITY_MSG_KIND : MSG_NONE;
    end
  end

  dpc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (pkt_evt),
    .clr   (cnt_rd),
    .value (err_cnt)
  );
endmodule

// File: rtl/dw_parity_check.sv
module dw_parity_check #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par,
  input  logic              chk_disable,
  input  logic              rpt_en,
  input  logic              cnt_rd,
  input  logic              sts_clr,
  output logic              out_eop,
  output logic              out_null,
  output logic              err_sts,
  output logic [CNT_W-1:0]  err_cnt,
  output logic              msg_req,
  output logic [1:0]        msg_kind
);
  logic word_bad;
  logic pkt_evt;

  dpc_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_par (
    .data     (in_data),
    .par      (in_par),
    .word_bad (word_bad)
  );

  dpc_pkt_track u_trk (
    .clk         (clk),
    .rst         (rst),
    .valid       (in_valid),
    .sop         (in_sop),
    .eop         (in_eop),
    .word_bad    (word_bad),
    .chk_disable (chk_disable),
    .pkt_evt     (pkt_evt),
    .out_eop     (out_eop),
    .out_null    (out_null)
  );

  dpc_err_report #(.CNT_W(CNT_W)) u_rep (
    .clk      (clk),
    .rst      (rst),
    .pkt_evt  (pkt_evt),
    .rpt_en   (rpt_en),
    .sts_clr  (sts_clr),
    .cnt_rd   (cnt_rd),
    .err_sts  (err_sts),
    .err_cnt  (err_cnt),
    .msg_req  (msg_req),
    .msg_kind (msg_kind)
  );
endmodule

// File: rtl/dpc_props.sv
module dpc_props #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_rd,
  input logic             sts_clr,
  input logic             out_eop,
  input logic             out_null,
  input logic             err_sts,
  input logic [CNT_W-1:0] err_cnt,
  input logic             msg_req,
  input logic [1:0]       msg_kind
);
  // R2
  null_needs_eop_chk: assert property (@(posedge clk) disable iff (rst)
    out_null |-> out_eop);

  // R3
  sts_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_sts && !sts_clr) |=> err_sts);

  // R4
  cnt_no_jump_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_rd |=> ((CNT_W+1)'(err_cnt) == (CNT_W+1)'($past(err_cnt)) ||
                 (CNT_W+1)'(err_cnt) == (CNT_W+1)'($past(err_cnt)) + 1'b1));

  // R5
  rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_rd |=> (err_cnt <= CNT_W'(1)));

  // R6
  msg_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> (err_sts && !$past(err_sts) && out_null));

  // R6
  msg_kind_chk: assert property (@(posedge clk) disable iff (rst)
    msg_req ? (msg_kind == 2'b01) : (msg_kind == 2'b00));
endmodule

bind dw_parity_check dpc_props #(.CNT_W(CNT_W)) u_props (
  .clk      (clk),
  .rst      (rst),
  .cnt_rd   (cnt_rd),
  .sts_clr  (sts_clr),
  .out_eop  (out_eop),
  .out_null (out_null),
  .err_sts  (err_sts),
  .err_cnt  (err_cnt),
  .msg_req  (msg_req),
  .msg_kind (msg_kind)
);

// File: tb/sim_dw_parity_check.sv
module sim_dw_parity_check;
  localparam int CLK_PER = 10;
  localparam int DW      = 32;
  localparam int CW      = 4;
  localparam int CMAX    = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_par = 0;
  logic [DW-1:0] in_data = '0;
  logic chk_disable = 0, rpt_en = 1, cnt_rd = 0, sts_clr = 0;
  logic out_eop, out_null, err_sts, msg_req;
  logic [CW-1:0] err_cnt;
  logic [1:0] msg_kind;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural reference state
  bit m_perr = 0, m_eop = 0, m_null = 0, m_sts = 0, m_msg = 0;
  int m_cnt = 0;

  always #(CLK_PER/2) clk = ~clk;

  dw_parity_check #(.DATA_W(DW), .LANE_W(8), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .in_par(in_par),
    .chk_disable(chk_disable), .rpt_en(rpt_en), .cnt_rd(cnt_rd),
    .sts_clr(sts_clr), .out_eop(out_eop), .out_null(out_null),
    .err_sts(err_sts), .err_cnt(err_cnt), .msg_req(msg_req),
    .msg_kind(msg_kind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference model: update from the inputs seen at the edge
  always @(posedge clk) begin
    bit w_bad, evt, base;
    if (rst) begin
      m_perr = 0; m_eop = 0; m_null = 0; m_sts = 0; m_msg = 0; m_cnt = 0;
    end else begin
      w_bad = in_valid && !chk_disable && ((^in_data) ^ in_par);
      base  = (in_valid && in_sop) ? 1'b0 : m_perr;
      evt   = in_valid && in_eop && (base || w_bad);
      if (in_valid) m_perr = in_eop ? 1'b0 : (base || w_bad);
      m_msg  = evt && rpt_en && !m_sts;
      m_sts  = evt ? 1'b1 : (sts_clr ? 1'b0 : m_sts);
      if (evt) m_cnt = cnt_rd ? 1 : ((m_cnt < CMAX) ? m_cnt + 1 : CMAX);
      else if (cnt_rd) m_cnt = 0;
      m_eop  = in_valid && in_eop;
      m_null = evt;
    end
  end

  // per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 out_eop", int'(out_eop), int'(m_eop));
      chk("R2 out_null", int'(out_null), int'(m_null));
      chk("R3 err_sts", int'(err_sts), int'(m_sts));
      chk("R4 err_cnt", int'(err_cnt), m_cnt);
      chk("R6 msg_req", int'(msg_req), int'(m_msg));
      chk("R6 msg_kind", int'(msg_kind), m_msg ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic beat(input bit v, input bit s, input bit e,
                      input logic [DW-1:0] d, input bit flip,
                      input bit rd = 0, input bit clr = 0);
    @(negedge clk);
    in_valid = v; in_sop = s; in_eop = e; in_data = d;
    in_par = (^d) ^ flip; cnt_rd = rd; sts_clr = clr;
  endtask

  task automatic idle(input bit rd = 0, input bit clr = 0);
    beat(0, 0, 0, '0, 0, rd, clr);
  endtask

  // three-word packet; bit i of badmask flips parity of word i
  task automatic pkt3(input logic [2:0] badmask, input logic [DW-1:0] seed,
                      input bit rd = 0, input bit clr = 0);
    beat(1, 1, 0, seed, badmask[0]);
    beat(1, 0, 0, seed ^ 32'h5A5A_0F0F, badmask[1]);
    beat(1, 0, 1, seed + 32'h1357_9BDF, badmask[2], rd, clr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset values
    chk("R8 sts", int'(err_sts), 0);
    chk("R8 cnt", int'(err_cnt), 0);
    chk("R8 msg", int'(msg_req) + int'(msg_kind) + int'(out_null) + int'(out_eop), 0);

    // R1 good parity, R2 clean packet
    pkt3(3'b000, 32'hDEAD_BEEF);
    idle();
    chk("R2 clean end", int'(out_eop), 1);
    chk("R1 good words not nullified", int'(out_null), 0);

    // R1 single bad word -> R2 null, R6 message, R3/R4
    pkt3(3'b010, 32'h0000_0001);
    idle();
    chk("R1 bad word nullifies", int'(out_null), 1);
    chk("R6 first message", int'(msg_req), 1);
    chk("R6 nonfatal kind", int'(msg_kind), 1);
    chk("R3 status set", int'(err_sts), 1);
    chk("R4 count one", int'(err_cnt), 1);

    // R9 several bad words, R6 silent while status set
    pkt3(3'b111, 32'hFFFF_0000);
    idle();
    chk("R9 one count per packet", int'(err_cnt), 2);
    chk("R6 no repeat message", int'(msg_req), 0);

    // R10 invalid beats with broken parity and framing
    beat(0, 1, 1, 32'h1234_5678, 1);
    beat(0, 0, 1, 32'h0000_00FF, 1);
    idle();
    chk("R10 invalid beats ignored", int'(err_cnt) + int'(out_eop) * 100, 2);
    // invalid bad beat inside a good packet
    beat(1, 1, 0, 32'hAAAA_5555, 0);
    beat(0, 0, 0, 32'h0F0F_0F0F, 1);
    beat(1, 0, 1, 32'h3333_CCCC, 0);
    idle();
    chk("R10 gap beat in packet", int'(out_null), 0);

    // R7 disabled checking
    chk_disable = 1;
    pkt3(3'b101, 32'h7777_1111);
    idle();
    chk_disable = 0;
    chk("R7 no null while disabled", int'(out_null), 0);
    chk("R7 count unchanged", int'(err_cnt), 2);

    // R3 clear alone, then R6 new message after clear
    idle(0, 1);
    idle();
    chk("R3 cleared by write", int'(err_sts), 0);
    pkt3(3'b001, 32'h2468_ACE0);
    idle();
    chk("R6 message after clear", int'(msg_req), 1);

    // R3 clear colliding with error: stays set, no message
    pkt3(3'b100, 32'h1111_2222, 0, 1);
    idle();
    chk("R3 error beats clear", int'(err_sts), 1);
    chk("R6 no message on collide", int'(msg_req), 0);

    // R5 read clears; read colliding with error gives 1
    idle(1, 0);
    idle();
    chk("R5 read clears", int'(err_cnt), 0);
    pkt3(3'b000, 32'h0);
    pkt3(3'b010, 32'h9999_8888);
    idle();
    pkt3(3'b010, 32'h4444_3333, 1, 0);
    idle();
    chk("R5 read with error gives one", int'(err_cnt), 1);

    // reporting disabled: no message on a fresh rise
    idle(0, 1);
    rpt_en = 0;
    pkt3(3'b001, 32'hCAFE_F00D);
    idle();
    chk("R6 no message when disabled", int'(msg_req), 0);
    rpt_en = 1;

    // R4 saturation
    for (int i = 0; i < CMAX + 5; i++) pkt3(3'b100, 32'h100 + i);
    idle();
    chk("R4 saturates", int'(err_cnt), CMAX);
    pkt3(3'b001, 32'h55);
    idle();
    chk("R4 holds at top", int'(err_cnt), CMAX);

    repeat (4) idle();
    finish_run();
  end
endmodule